// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Selector

This block decides whether a synchronous buck controller runs in fixed-frequency PWM or in variable-frequency hysteretic (pulse-skipping) operation. Once per switching period the power stage supplies a strobe together with the polarity of the switch node, taken at the end of low-side conduction. A negative node means the inductor current is still flowing forward, which favours PWM. A positive node means the current has reversed, which favours hysteretic operation. The block switches mode only after an unbroken run of samples that all point the same way. A single contrary sample throws the pending run away.

Several conditions hold the converter in PWM and clear any run in progress: the hysteretic-enable input driven low, soft start, a reference-code slew, and a move between the alternate and coded setpoints. A sudden load step seen in hysteretic mode also forces PWM. The step shows up as the output dropping below the deepest comparator threshold. Every mode change takes effect at a switching-period boundary.

While hysteretic mode is active, the block turns three digital comparator flags into a registered high-side on-request. The request sets when the output is below the lower threshold and clears when it is above the upper one. The comparators themselves sit outside the block.

Top module: `buck_mode_sel`

## Requirements
- R1: While reset is asserted, and on its release, `hyst_mode` = 0 (PWM), `hs_on_req` = 0 and `cycle_tick` = 0.
- R2: In PWM, RUN_LEN (8) consecutive strobed samples with `sw_pos` = 1 (positive node) switch `hyst_mode` to 1.
- R3: In hysteretic mode, RUN_LEN consecutive strobed samples with `sw_pos` = 0 switch `hyst_mode` back to 0.
- R4: A sample of the opposite polarity restarts the run, so a full new run of RUN_LEN matching samples is needed after it.
- R5: While `hyst_enable` is 0, hysteretic mode is never entered, and a strobe taken in hysteretic mode returns the block to PWM.
- R6: `ss_busy`, `code_moving` or `setpt_moving` high returns the block to PWM at the next strobe and blocks entry to hysteretic mode.
- R7: In hysteretic mode, `vout_lt_floor` = 1 in any cycle, even for a single cycle, forces PWM at the next strobe, whatever the polarity of that sample.
- R8: In hysteretic mode, `hs_on_req` goes to 1 one clock after `vout_lt_low` = 1 and to 0 one clock after `vout_gt_high` = 1 (with the default SET_WINS = 1, set takes priority). Otherwise it holds its value. In PWM it is 0.
- R9: Any override condition (R5 to R7) clears the run counter. The first strobe after an override is consumed by that override, and a new run starts only with the sample that follows.
- R10: `cycle_tick` is `cyc_strobe` delayed by SMP_STAGES clocks. `hyst_mode` changes only on the clock that follows a cycle where `cycle_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-clock pulse per switching period, at the end of low-side conduction |
| sw_pos | input | 1 | Switch-node polarity at the strobe: 1 = positive, 0 = negative |
| hyst_enable | input | 1 | 0 blocks hysteretic mode |
| ss_busy | input | 1 | Soft start in progress |
| code_moving | input | 1 | Reference code slewing |
| setpt_moving | input | 1 | Switching between the alternate and coded setpoints |
| vout_lt_floor | input | 1 | Output below reference minus 20 mV |
| vout_lt_low | input | 1 | Output below reference minus 10 mV |
| vout_gt_high | input | 1 | Output above reference plus 5 mV |
| cycle_tick | output | 1 | Registered strobe that marks the switching-period boundary |
| hyst_mode | output | 1 | 1 = hysteretic, 0 = PWM |
| hs_on_req | output | 1 | High-side on-request in hysteretic mode |

## Verification
The bench builds the block with its defaults: RUN_LEN = 8, SMP_STAGES = 1 and SET_WINS = 1. These values give the full eight-sample run in both directions and a one-clock strobe path, so each run length and each override position can be reached and counted exactly. Directed sequences drive runs that end one sample short, runs broken by a contrary sample, one-cycle override pulses placed between strobes, and floor escapes on a sample whose polarity would otherwise match. A seeded random phase then mixes polarity runs, overrides and comparator flags, and a bench model follows the outputs cycle by cycle.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;
   typedef enum logic {
      MODE_PWM  = 1'b0,
      MODE_HYST = 1'b1
   } conv_mode_e;
endpackage

// File: rtl/bms_sign_sampler.sv
module bms_sign_sampler #(
   parameter int SMP_STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   input  logic pos_in,
   output logic tick_out,
   output logic pos_out
);
   initial assert (SMP_STAGES >= 1) else $error("SMP_STAGES must be at least 1");

   logic [SMP_STAGES-1:0] stb_sr;
   logic [SMP_STAGES-1:0] pos_sr;

   generate
      if (SMP_STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stb_sr <= '0;
               pos_sr <= '0;
            end else begin
               stb_sr <= strobe_in;
               pos_sr <= pos_in;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stb_sr <= '0;
               pos_sr <= '0;
            end else begin
               stb_sr <= {stb_sr[SMP_STAGES-2:0], strobe_in};
               pos_sr <= {pos_sr[SMP_STAGES-2:0], pos_in};
            end
         end
      end
   endgenerate

   assign tick_out = stb_sr[SMP_STAGES-1];
   assign pos_out  = pos_sr[SMP_STAGES-1];

   generate
      if (SMP_STAGES == 1) begin : g_chk
         AST_TICK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            strobe_in |=> tick_out); // R10
      end
   endgenerate
endmodule

// File: rtl/bms_run_debounce.sv
module bms_run_debounce
   import buck_mode_pkg::*;
#(
   parameter int RUN_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       pos,
   input  logic       force_pwm,
   output conv_mode_e mode
);
   localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   initial assert (RUN_LEN >= 2) else $error("RUN_LEN must be at least 2");

   conv_mode_e       mode_q;
   logic [CNT_W-1:0] run_q;
   logic             demand_q;
   logic             want;

   // a sample supports a change when it points away from the current mode
   assign want = (mode_q == MODE_PWM) ? pos : ~pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_PWM;
         run_q    <= '0;
         demand_q <= 1'b0;
      end else if (tick) begin
         demand_q <= force_pwm;
         if (demand_q || force_pwm) begin
            mode_q <= MODE_PWM;
            run_q  <= '0;
         end else if (want) begin
            if (run_q == LAST) begin
               mode_q <= (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end else begin
         demand_q <= demand_q | force_pwm;
         if (demand_q || force_pwm) run_q <= '0;
      end
   end

   assign mode = mode_q;

   AST_MODE_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(mode_q)); // R10
   AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      force_pwm |=> (run_q == '0)); // R9
   AST_FORCED_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && force_pwm) |=> (mode_q == MODE_PWM)); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == LAST && tick && want && !force_pwm && !demand_q) |=> (run_q == '0)); // R2
endmodule

// File: rtl/bms_hyst_request.sv
module bms_hyst_request #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic below_low,
   input  logic above_high,
   output logic on_req
);
   logic req_q;
   logic req_d;

   generate
      if (SET_WINS) begin : g_set_prio
         always_comb begin
            if (below_low)       req_d = 1'b1;
            else if (above_high) req_d = 1'b0;
            else                 req_d = req_q;
         end
      end else begin : g_clr_prio
         always_comb begin
            if (above_high)     req_d = 1'b0;
            else if (below_low) req_d = 1'b1;
            else                req_d = req_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (!active) req_q <= 1'b0;
      else             req_q <= req_d;
   end

   assign on_req = req_q;

   AST_REQ_IDLE_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !on_req); // R8
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !below_low && !above_high) |=> (on_req == $past(on_req))); // R8
endmodule

// File: rtl/buck_mode_sel.sv
module buck_mode_sel
   import buck_mode_pkg::*;
#(
   parameter int RUN_LEN    = 8,
   parameter int SMP_STAGES = 1,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_strobe,
   input  logic sw_pos,
   input  logic hyst_enable,
   input  logic ss_busy,
   input  logic code_moving,
   input  logic setpt_moving,
   input  logic vout_lt_floor,
   input  logic vout_lt_low,
   input  logic vout_gt_high,
   output logic cycle_tick,
   output logic hyst_mode,
   output logic hs_on_req
);
   logic       tick;
   logic       pos;
   logic       force_pwm;
   logic       in_hyst;
   conv_mode_e mode;

   bms_sign_sampler #(.SMP_STAGES(SMP_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n),
      .strobe_in(cyc_strobe), .pos_in(sw_pos),
      .tick_out(tick), .pos_out(pos)
   );

   assign in_hyst   = (mode == MODE_HYST);
   assign force_pwm = ~hyst_enable | ss_busy | code_moving | setpt_moving
                    | (in_hyst & vout_lt_floor);

   bms_run_debounce #(.RUN_LEN(RUN_LEN)) u_deb (
      .clk(clk), .rst_n(rst_n),
      .tick(tick), .pos(pos), .force_pwm(force_pwm),
      .mode(mode)
   );

   bms_hyst_request #(.SET_WINS(SET_WINS)) u_req (
      .clk(clk), .rst_n(rst_n),
      .active(in_hyst), .below_low(vout_lt_low), .above_high(vout_gt_high),
      .on_req(hs_on_req)
   );

   assign cycle_tick = tick;
   assign hyst_mode  = in_hyst;

   AST_HOLD_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (ss_busy || code_moving || setpt_moving)) |=> !hyst_mode); // R6
   AST_FLOOR_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && hyst_mode && vout_lt_floor) |=> !hyst_mode); // R7
endmodule

// File: tb/tb_buck_mode_sel.sv
`timescale 1ns/1ps
module tb_buck_mode_sel;
   localparam int RUN = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 0, pos = 0, hen = 1, ss = 0, code = 0, setpt = 0;
   logic flr = 0, lo = 0, hi = 0;
   logic tick_o, hyst_o, req_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   bit cmp_on = 0;

   always #5 clk = ~clk;

   buck_mode_sel dut (
      .clk(clk), .rst_n(rst_n), .cyc_strobe(strobe), .sw_pos(pos),
      .hyst_enable(hen), .ss_busy(ss), .code_moving(code), .setpt_moving(setpt),
      .vout_lt_floor(flr), .vout_lt_low(lo), .vout_gt_high(hi),
      .cycle_tick(tick_o), .hyst_mode(hyst_o), .hs_on_req(req_o)
   );

   // bench model built from the requirements
   bit m_tick, m_pos, m_hyst, m_req, m_dem;
   int m_cnt;

   function automatic bit demand_now(bit h);
      return !hen || ss || code || setpt || (h && flr);
   endfunction

   function automatic bit next_req(bit h, bit r);
      if (!h) return 0;
      if (lo) return 1;
      if (hi) return 0;
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tick = 0; m_pos = 0; m_hyst = 0; m_req = 0; m_dem = 0; m_cnt = 0;
      end else begin
         bit dn;
         bit nr;
         dn = demand_now(m_hyst);
         nr = next_req(m_hyst, m_req);
         if (m_tick) begin
            if (m_dem || dn) begin
               m_hyst = 0; m_cnt = 0;
            end else if (m_pos ^ m_hyst) begin
               if (m_cnt == RUN - 1) begin m_hyst = !m_hyst; m_cnt = 0; end
               else m_cnt++;
            end else m_cnt = 0;
            m_dem = dn;
         end else begin
            if (m_dem || dn) m_cnt = 0;
            m_dem = m_dem || dn;
         end
         m_req = nr;
         m_tick = strobe;
         m_pos = pos;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2 R3 model mode", hyst_o, m_hyst);
         chk("R8 model request", req_o, m_req);
         chk("R10 model tick", tick_o, m_tick);
      end
   end

   task automatic tick_smp(input bit p);
      @(negedge clk); strobe = 1; pos = p;
      @(negedge clk); strobe = 0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n, input bit p);
      for (int k = 0; k < n; k++) tick_smp(p);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset mode", hyst_o, 0);
      chk("R1 reset request", req_o, 0);
      chk("R1 reset tick", tick_o, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 after release mode", hyst_o, 0);
      cmp_on = 1;

      // R2: one short of a full run, then complete it
      ticks(RUN - 1, 1);
      chk("R2 seven positive stays PWM", hyst_o, 0);
      tick_smp(1);
      chk("R2 eighth positive enters hyst", hyst_o, 1);

      // R8: request set and clear
      @(negedge clk); lo = 1;
      @(negedge clk); lo = 0;
      chk("R8 request set", req_o, 1);
      @(negedge clk);
      chk("R8 request held", req_o, 1);
      hi = 1;
      @(negedge clk); hi = 0;
      chk("R8 request cleared", req_o, 0);

      // R4: broken run, then R3 full run
      ticks(RUN - 1, 0);
      tick_smp(1);
      ticks(RUN - 1, 0);
      chk("R4 mismatch restarts run", hyst_o, 1);
      tick_smp(0);
      chk("R3 eighth negative returns PWM", hyst_o, 0);

      // R5: enable low blocks entry
      hen = 0;
      ticks(RUN + 2, 1);
      chk("R5 disabled stays PWM", hyst_o, 0);
      hen = 1;
      // R9: first strobe consumed, so eight more leave PWM
      ticks(RUN, 1);
      chk("R9 run cleared by override", hyst_o, 0);
      tick_smp(1);
      chk("R9 fresh run completes", hyst_o, 1);

      // R7: one-cycle floor pulse between strobes
      @(negedge clk); lo = 1; flr = 1;
      @(negedge clk); lo = 0; flr = 0;
      repeat (3) @(negedge clk);
      chk("R10 mode waits for boundary", hyst_o, 1);
      tick_smp(1);
      chk("R7 floor escape to PWM", hyst_o, 0);
      chk("R8 request zero in PWM", req_o, 0);

      // R6: each hold condition
      for (int h = 0; h < 3; h++) begin
         ticks(RUN, 1);
         chk("R6 re-entered hyst", hyst_o, 1);
         @(negedge clk);
         ss = (h == 0); code = (h == 1); setpt = (h == 2);
         @(negedge clk); ss = 0; code = 0; setpt = 0;
         tick_smp(0);
         chk("R6 hold forces PWM", hyst_o, 0);
         tick_smp(1);
      end

      // random phase
      begin
         bit sgn;
         sgn = 1;
         void'($urandom(32'd4242));
         for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            strobe = (i % 4 == 0);
            if ($urandom % 12 == 0) sgn = !sgn;
            pos = sgn;
            hen = ($urandom % 60) != 0;
            ss = ($urandom % 90) == 0;
            code = ($urandom % 90) == 0;
            setpt = ($urandom % 90) == 0;
            flr = ($urandom % 70) == 0;
            lo = ($urandom % 5) == 0;
            hi = ($urandom % 5) == 0;
         end
      end
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule